// File: doc/BRIEF.md
# Parallel Cable Two-Way Byte Handshake Host

This block is the host end of a bidirectional 8-bit parallel cable link. In the forward direction it takes bytes from an internal valid/ready stream, puts each one on the cable data lines together with a data-or-command tag, and strobes it across using an interlocked handshake with the peripheral's busy line. In the reverse direction it asks the peripheral to turn the link around. It waits for the peripheral to confirm the new direction, then accepts bytes that the peripheral clocks onto the cable. Each received byte is tagged as data or command and handed out on a second valid/ready stream.

All cable inputs pass through a chain of synchroniser flops before the state machine sees them. The host drives the data lines only while the direction-confirm input shows forward. A programmable stall limit aborts any handshake that waits too long and raises a sticky error flag. The flag clears only on reset.

Stream rules: a forward byte is taken on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is high only in forward idle with no reverse request, so at most one byte is in flight. A received byte is held on `rx_data_o`/`rx_cmd_o` with `rx_valid_o` high until a clock edge with `rx_ready_i` high. While that byte waits, the host does not acknowledge a new one, so the back-pressure reaches the peripheral.

Top module: `ecp_host_link`

## Requirements
- R1: Out of reset, `fwd_strobe_o`=1, `cab_data_oe_o`=0, `rev_req_o`=1, `tx_ready_o`=0, `rx_valid_o`=0 and `stall_err_o`=0.
- R2: `cab_data_oe_o` rises only after the synchronised `dir_conf_i` has been seen high. While `dir_conf_i` stays low in forward mode, the bus is not driven and no byte is accepted.
- R3: An accepted forward byte appears on `cab_data_o`. `fwd_strobe_o` falls only after `peer_flag_i` has been low, and the data stay stable while the strobe is low. `fwd_strobe_o` returns high after `peer_flag_i` goes high.
- R4: While a forward byte is pending or strobed, `host_reply_o` is 1 for a data byte (`tx_cmd_i`=0) and 0 for a command byte (`tx_cmd_i`=1).
- R5: `tx_ready_o` is 0 from acceptance of a byte until its strobe has returned high.
- R6: With `dir_rev_i`=1 in forward idle, the host stops driving the bus and drives `rev_req_o` low. No reverse byte is taken until `dir_conf_i` goes low.
- R7: In reverse, when `peer_valid_i` goes low the host captures `cab_data_i` and sets `host_reply_o`=1. It returns `host_reply_o` to 0 after `peer_valid_i` goes high.
- R8: `rx_cmd_o` is the inverse of `peer_flag_i` at capture: 1 = command byte, 0 = data byte.
- R9: While `rx_valid_o`=1 and `rx_ready_i`=0, `rx_data_o` holds and no further byte is acknowledged (`host_reply_o` stays 0).
- R10: With `dir_rev_i`=0 in reverse idle, `rev_req_o` returns to 1. The bus stays undriven until `dir_conf_i` is high again.
- R11: A non-zero `stall_limit_i` of N aborts a handshake that has waited N cycles in one state. The abort sets the sticky `stall_err_o`, drops the pending byte and returns the strobe high. A limit of 0 disables the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_rev_i | input | 1 | 1 requests reverse direction, 0 forward |
| tx_valid_i | input | 1 | Forward byte valid |
| tx_ready_o | output | 1 | Forward byte can be accepted |
| tx_data_i | input | 8 | Forward byte |
| tx_cmd_i | input | 1 | Forward byte is a command |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Consumer takes received byte |
| rx_data_o | output | 8 | Received byte |
| rx_cmd_o | output | 1 | Received byte is a command |
| stall_limit_i | input | 16 | Stall abort limit in cycles, 0 disables |
| stall_err_o | output | 1 | Sticky stall error |
| cab_data_o | output | 8 | Cable data out |
| cab_data_oe_o | output | 1 | Cable data output enable |
| cab_data_i | input | 8 | Cable data in |
| fwd_strobe_o | output | 1 | Forward strobe, active low |
| host_reply_o | output | 1 | Forward tag / reverse acknowledge |
| rev_req_o | output | 1 | Reverse request, active low |
| peer_valid_i | input | 1 | Peripheral data strobe, active low |
| peer_flag_i | input | 1 | Peripheral busy (forward) / tag (reverse) |
| dir_conf_i | input | 1 | Direction confirm, high = forward |

## Verification
The bench holds `peer_flag_i` high for a long time before releasing it. A host that strobes without waiting would show the strobe low too early, and one that ignores the limit-0 setting would raise the error. It holds the direction confirm low both at start-up and on the way back to forward: a design that drives the bus early shows `cab_data_oe_o` high. It presents a second reverse byte while the first is unconsumed, which catches an overwrite or an early acknowledge. It stalls a strobe past a small limit to check that the error is set, that the byte is dropped and that no stray strobe follows.

// File: rtl/ecp_host_pkg.sv
package ecp_host_pkg;
  typedef enum logic [2:0] {
    ST_TURN_FWD,
    ST_F_IDLE,
    ST_F_SETUP,
    ST_F_STROBE,
    ST_REQ_REV,
    ST_R_IDLE,
    ST_R_ACK
  } link_state_e;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ecp_stall_timer.sv
module ecp_stall_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  // Fires in the limit-th consecutive cycle spent in one waiting state.
  assign expired = run && (limit != '0) && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          cnt_q <= '0;
    else if (!run || restart || expired) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/ecp_link_fsm.sv
module ecp_link_fsm
  import ecp_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rev_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_cmd_i,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_cmd_o,
  input  logic [DW-1:0] data_s,
  input  logic          pvalid_s,
  input  logic          pflag_s,
  input  logic          conf_s,
  input  logic          expired_i,
  output logic          wait_run_o,
  output logic          wait_restart_o,
  output logic          stall_err_o,
  output logic [DW-1:0] cab_data_o,
  output logic          cab_data_oe_o,
  output logic          fwd_strobe_o,
  output logic          host_reply_o,
  output logic          rev_req_o
);
  link_state_e  state_q, state_d;
  logic [DW-1:0] tx_q, rx_q;
  logic          cmd_q, rx_cmd_q, rx_valid_q, err_q;
  logic          tx_take, rx_take;

  assign tx_ready_o = (state_q == ST_F_IDLE) && !dir_rev_i;
  assign tx_take    = tx_valid_i && tx_ready_o;
  assign rx_take    = (state_q == ST_R_IDLE) && dir_rev_i && !pvalid_s && !rx_valid_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TURN_FWD: if (conf_s) state_d = ST_F_IDLE;
      ST_F_IDLE: begin
        if (dir_rev_i)    state_d = ST_REQ_REV;
        else if (tx_take) state_d = ST_F_SETUP;
      end
      ST_F_SETUP:  if (!pflag_s) state_d = ST_F_STROBE;
      ST_F_STROBE: if (pflag_s)  state_d = ST_F_IDLE;
      ST_REQ_REV:  if (!conf_s)  state_d = ST_R_IDLE;
      ST_R_IDLE: begin
        if (!dir_rev_i)   state_d = ST_TURN_FWD;
        else if (rx_take) state_d = ST_R_ACK;
      end
      ST_R_ACK:    if (pvalid_s) state_d = ST_R_IDLE;
      default:     state_d = ST_TURN_FWD;
    endcase
    if (expired_i && state_q != ST_TURN_FWD) state_d = ST_TURN_FWD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_TURN_FWD;
      tx_q       <= '0;
      cmd_q      <= 1'b0;
      rx_q       <= '0;
      rx_cmd_q   <= 1'b0;
      rx_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tx_take) begin
        tx_q  <= tx_data_i;
        cmd_q <= tx_cmd_i;
      end
      if (rx_take) begin
        rx_q       <= data_s;
        rx_cmd_q   <= !pflag_s;
        rx_valid_q <= 1'b1;
      end else if (rx_valid_q && rx_ready_i) begin
        rx_valid_q <= 1'b0;
      end
      if (expired_i) err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_TURN_FWD, ST_F_IDLE:  host_reply_o = 1'b1;
      ST_F_SETUP, ST_F_STROBE: host_reply_o = !cmd_q;
      ST_R_ACK:                host_reply_o = 1'b1;
      default:                 host_reply_o = 1'b0;
    endcase
  end

  assign wait_run_o     = (state_q == ST_TURN_FWD) || (state_q == ST_F_SETUP) ||
                          (state_q == ST_F_STROBE) || (state_q == ST_REQ_REV) ||
                          (state_q == ST_R_ACK);
  assign wait_restart_o = (state_d != state_q);
  assign fwd_strobe_o   = (state_q != ST_F_STROBE);
  assign cab_data_oe_o  = (state_q == ST_F_IDLE) || (state_q == ST_F_SETUP) ||
                          (state_q == ST_F_STROBE);
  assign rev_req_o      = !((state_q == ST_REQ_REV) || (state_q == ST_R_IDLE) ||
                            (state_q == ST_R_ACK));
  assign cab_data_o     = tx_q;
  assign rx_data_o      = rx_q;
  assign rx_cmd_o       = rx_cmd_q;
  assign rx_valid_o     = rx_valid_q;
  assign stall_err_o    = err_q;

  // Bus enable only turns on after a forward confirmation was sampled.
  assert_oe_after_conf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cab_data_oe_o) |-> $past(conf_s));

  // Strobe falls only after the peripheral showed not-busy.
  assert_strobe_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fwd_strobe_o) |-> !$past(pflag_s));

  // Data lines hold while the strobe stays low.
  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_strobe_o && $past(!fwd_strobe_o)) |-> $stable(cab_data_o));

  // Reverse acknowledge rises only after the peripheral strobe was low.
  assert_reply_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_reply_o) && !rev_req_o) |-> !$past(pvalid_s));

  // A waiting received byte is held until taken.
  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
endmodule

// File: rtl/ecp_host_link.sv
module ecp_host_link #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rev_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic [DW-1:0]    tx_data_i,
  input  logic             tx_cmd_i,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_cmd_o,
  input  logic [TMO_W-1:0] stall_limit_i,
  output logic             stall_err_o,
  output logic [DW-1:0]    cab_data_o,
  output logic             cab_data_oe_o,
  input  logic [DW-1:0]    cab_data_i,
  output logic             fwd_strobe_o,
  output logic             host_reply_o,
  output logic             rev_req_o,
  input  logic             peer_valid_i,
  input  logic             peer_flag_i,
  input  logic             dir_conf_i
);
  localparam int IN_W = DW + 3;
  localparam logic [IN_W-1:0] SYNC_RST = {1'b0, 2'b11, {DW{1'b0}}};

  logic [IN_W-1:0] raw_in, syn_in;
  logic            run, restart, expired;

  assign raw_in = {dir_conf_i, peer_flag_i, peer_valid_i, cab_data_i};

  ecp_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  ecp_stall_timer #(.CNT_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .limit(stall_limit_i), .expired(expired)
  );

  ecp_link_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dir_rev_i(dir_rev_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .tx_data_i(tx_data_i), .tx_cmd_i(tx_cmd_i),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .rx_data_o(rx_data_o), .rx_cmd_o(rx_cmd_o),
    .data_s(syn_in[DW-1:0]), .pvalid_s(syn_in[DW]),
    .pflag_s(syn_in[DW+1]), .conf_s(syn_in[DW+2]),
    .expired_i(expired), .wait_run_o(run), .wait_restart_o(restart),
    .stall_err_o(stall_err_o), .cab_data_o(cab_data_o),
    .cab_data_oe_o(cab_data_oe_o), .fwd_strobe_o(fwd_strobe_o),
    .host_reply_o(host_reply_o), .rev_req_o(rev_req_o)
  );
endmodule

// File: tb/ecp_host_link_tb.sv
`timescale 1ns/1ps
module ecp_host_link_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rev = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_cmd = 1'b0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_cmd;
  logic [15:0] tmo = 16'd0;
  logic        err;
  logic [7:0]  cdata;
  logic        coe;
  logic [7:0]  pdata = 8'h00;
  logic        strobe, reply, rreq;
  logic        pvalid = 1'b1;
  logic        pflag = 1'b1;
  logic        conf = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ecp_host_link dut_i (
    .clk(clk), .rst_n(rst_n), .dir_rev_i(dir_rev),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data), .tx_cmd_i(tx_cmd),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data), .rx_cmd_o(rx_cmd),
    .stall_limit_i(tmo), .stall_err_o(err),
    .cab_data_o(cdata), .cab_data_oe_o(coe), .cab_data_i(pdata),
    .fwd_strobe_o(strobe), .host_reply_o(reply), .rev_req_o(rreq),
    .peer_valid_i(pvalid), .peer_flag_i(pflag), .dir_conf_i(conf)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // which: 0 strobe, 1 reply, 2 oe, 3 err; polls at negedges, bounded.
  task automatic wait_sig(input int which, input logic lvl, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      case (which)
        0: ok = (strobe == lvl);
        1: ok = (reply == lvl);
        2: ok = (coe == lvl);
        default: ok = (err == lvl);
      endcase
      if (ok) break;
    end
  endtask

  task automatic push_tx(input logic [7:0] d, input logic c);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_cmd = c;
    for (int i = 0; i < 40; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send_fwd(input logic [7:0] d, input logic c, input int hold, input string req);
    bit ok;
    pflag = 1'b1;
    push_tx(d, c);
    chk({req, " tx_ready low in flight R5"}, tx_ready, 1'b0);
    repeat (hold) @(negedge clk);
    chk({req, " no strobe while busy R3"}, strobe, 1'b1);
    chk({req, " data on bus R3"}, cdata, d);
    chk({req, " tag level R4"}, reply, !c);
    pflag = 1'b0;
    wait_sig(0, 1'b0, ok);
    chk({req, " strobe fell R3"}, ok, 1'b1);
    chk({req, " data at strobe R3"}, {coe, cdata}, {1'b1, d});
    pflag = 1'b1;
    wait_sig(0, 1'b1, ok);
    chk({req, " strobe rose R3"}, ok, 1'b1);
    @(negedge clk);
    chk({req, " ready after byte R5"}, tx_ready, 1'b1);
  endtask

  task automatic recv_rev(input logic [7:0] d, input logic c, input string req);
    bit ok;
    pdata = d; pflag = !c;
    @(negedge clk);
    pvalid = 1'b0;
    wait_sig(1, 1'b1, ok);
    chk({req, " reply raised R7"}, ok, 1'b1);
    chk({req, " rx data R7"}, {rx_valid, rx_data}, {1'b1, d});
    chk({req, " rx tag R8"}, rx_cmd, c);
    pvalid = 1'b1;
    wait_sig(1, 1'b0, ok);
    chk({req, " reply dropped R7"}, ok, 1'b1);
  endtask

  task automatic take_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    bit ok;
    @(negedge clk);
    chk("reset strobe R1", strobe, 1'b1);
    chk("reset oe R1", coe, 1'b0);
    chk("reset rreq R1", rreq, 1'b1);
    chk("reset ready R1", tx_ready, 1'b0);
    chk("reset rx_valid R1", rx_valid, 1'b0);
    chk("reset err R1", err, 1'b0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("no drive before confirm R2", {coe, tx_ready}, 2'b00);
    conf = 1'b1;
    wait_sig(2, 1'b1, ok);
    chk("drive after confirm R2", ok, 1'b1);
    chk("ready after confirm R2", tx_ready, 1'b1);
  endtask

  task automatic t_forward();
    send_fwd(8'hA5, 1'b0, 3, "fwd data");
    send_fwd(8'h3C, 1'b0, 30, "fwd long busy");
    chk("limit 0 no error R11", err, 1'b0);
  endtask

  task automatic t_command();
    send_fwd(8'h81, 1'b1, 2, "fwd cmd");
  endtask

  task automatic t_reverse();
    @(negedge clk); dir_rev = 1'b1;
    repeat (3) @(negedge clk);
    chk("rev oe off R6", coe, 1'b0);
    chk("rev request R6", rreq, 1'b0);
    chk("rev not ready R6", tx_ready, 1'b0);
    pdata = 8'h55; pflag = 1'b1; pvalid = 1'b0;
    repeat (6) @(negedge clk);
    chk("no ack before confirm R6", {reply, rx_valid}, 2'b00);
    pvalid = 1'b1;
    repeat (4) @(negedge clk);
    conf = 1'b0;
    repeat (4) @(negedge clk);
    recv_rev(8'h5A, 1'b0, "rev data");
    take_rx();
    recv_rev(8'hC3, 1'b1, "rev cmd");
    take_rx();
  endtask

  task automatic t_backpressure();
    bit ok;
    recv_rev(8'h11, 1'b0, "bp first");
    pdata = 8'h22; pflag = 1'b1;
    @(negedge clk); pvalid = 1'b0;
    repeat (10) @(negedge clk);
    chk("bp no ack R9", reply, 1'b0);
    chk("bp hold R9", {rx_valid, rx_data}, {1'b1, 8'h11});
    take_rx();
    wait_sig(1, 1'b1, ok);
    chk("bp second acked R9", ok, 1'b1);
    chk("bp second data R9", {rx_valid, rx_data}, {1'b1, 8'h22});
    pvalid = 1'b1;
    wait_sig(1, 1'b0, ok);
    take_rx();
  endtask

  task automatic t_return();
    bit ok;
    @(negedge clk); dir_rev = 1'b0;
    repeat (5) @(negedge clk);
    chk("return rreq high R10", rreq, 1'b1);
    chk("return no drive R10", coe, 1'b0);
    conf = 1'b1;
    wait_sig(2, 1'b1, ok);
    chk("return drive R10", ok, 1'b1);
  endtask

  task automatic t_timeout();
    bit ok;
    bit saw_low;
    tmo = 16'd8;
    pflag = 1'b1;
    push_tx(8'h77, 1'b0);
    repeat (3) @(negedge clk);
    chk("no early error R11", err, 1'b0);
    wait_sig(3, 1'b1, ok);
    chk("stall error set R11", ok, 1'b1);
    chk("strobe high after abort R11", strobe, 1'b1);
    pflag = 1'b0;
    saw_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!strobe) saw_low = 1'b1;
    end
    chk("dropped byte no strobe R11", saw_low, 1'b0);
    chk("ready after abort R11", tx_ready, 1'b1);
    chk("error sticky R11", err, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_forward();
    t_command();
    t_reverse();
    t_backpressure();
    t_return();
    t_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule